// File: doc/BRIEF.md
# Escape-Code Run-Length Byte Expander

This block turns a compressed byte stream back into its original form. The stream uses a single reserved escape symbol. Any byte other than the escape is a literal and goes to the output once. An escape byte opens a group of three bytes: the escape itself, a value byte and a count byte. The block answers such a group by emitting the value as many times as the count asks. This makes it a good fit for unpacking configuration images, which hold long runs of identical bytes.

Bytes come in over a valid/ready handshake. Each input byte carries an end-of-stream marker. Expanded bytes go out over a second valid/ready handshake, and the consumer may stall that output at any time. A literal escape byte is sent as escape, escape, count one. If the stream ends part-way through a group, the block drops the partial group and raises a sticky flag.

Top module: `rle_escape_expander`

## Requirements
- R1: An accepted input byte that differs from the escape code, arriving while no group is open, produces exactly one output byte with the same value. That byte is presented in the cycle after acceptance whenever the output slot is free.
- R2: The sequence escape, V, C with C in 1..255 produces exactly C output bytes of value V, in order, before any byte that follows C in the input.
- R3: A count byte of 8'h00 produces 256 copies of the value.
- R4: The byte after an escape is always taken as the value, even when it equals the escape code. The sequence escape, escape, 8'h01 therefore yields one escape byte.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data keeps its value on the next cycle. No output byte is lost or repeated under backpressure.
- R6: in_ready is 0 while an output byte is held and is not the final copy being accepted in that cycle. Input that follows a run is therefore taken only after the run has drained.
- R7: If in_last is 1 on an accepted escape byte that opens a group, or on an accepted value byte, err_trunc goes to 1 in the next cycle. The partial group produces no output, and the next byte is decoded as a literal.
- R8: err_trunc stays 1 until reset. in_last on a literal byte or on a count byte does not set it.
- R9: After a synchronous reset, out_valid is 0, in_ready is 1, err_trunc is 0, and the first byte is decoded as a literal or an escape.
- R10: The escape code is the parameter ESC_CODE and defaults to 8'h81. Symbols are DATA_W = 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Compressed input byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Expanded byte is valid |
| out_data | output | 8 | Expanded output byte |
| out_ready | input | 1 | Consumer accepts the output byte this cycle |
| err_trunc | output | 1 | Sticky flag for a group cut short by end of stream |

## Verification
A parser stuck in a wrong group state shows up within one accepted byte. Either a literal never appears on the output, or a value or count byte leaks out as a literal, so the output sequence diverges from the reference at that position. An off-by-one in the run counter shows as one byte too many or too few at the end of a run. That slip shifts every later byte, which is why whole streams are compared byte by byte, both under random stalls and with no stalls. A run counter that slips under backpressure changes out_data during a stall, and the check fires in the very next cycle.

// File: rtl/rle_pkg.sv
package rle_pkg;

    // Position inside an escape group
    typedef enum logic [1:0] {
        PS_LIT = 2'd0,  // no group open
        PS_ESC = 2'd1,  // escape seen, value expected
        PS_VAL = 2'd2   // value held, count expected
    } parse_state_e;

endpackage

// File: rtl/rle_group_parser.sv
module rle_group_parser
    import rle_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] ESC_CODE = 8'h81,
    localparam int               CNT_W    = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              byte_last,
    output logic              load,
    output logic [DATA_W-1:0] load_data,
    output logic [CNT_W-1:0]  load_cnt,
    output logic              trunc
);

    typedef struct packed {
        parse_state_e      st;
        logic [DATA_W-1:0] val;
    } pstate_t;

    pstate_t ps_d, ps_q;

    always_comb begin
        ps_d      = ps_q;
        load      = 1'b0;
        load_data = byte_in;
        load_cnt  = CNT_W'(1);
        trunc     = 1'b0;
        if (take) begin
            case (ps_q.st)
                PS_LIT: begin
                    if (byte_in == ESC_CODE) begin
                        if (byte_last) trunc = 1'b1;
                        else           ps_d.st = PS_ESC;
                    end else begin
                        load = 1'b1;
                    end
                end
                PS_ESC: begin
                    // value byte is taken verbatim, escape included (R4)
                    ps_d.val = byte_in;
                    if (byte_last) begin
                        trunc   = 1'b1;
                        ps_d.st = PS_LIT;
                    end else begin
                        ps_d.st = PS_VAL;
                    end
                end
                PS_VAL: begin
                    load      = 1'b1;
                    load_data = ps_q.val;
                    // zero count stands for the full 2**DATA_W copies (R3)
                    load_cnt  = (byte_in == '0) ? {1'b1, {DATA_W{1'b0}}}
                                                : {1'b0, byte_in};
                    ps_d.st   = PS_LIT;
                end
                default: ps_d.st = PS_LIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q.st  <= PS_LIT;
            ps_q.val <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    // R7: a group only ends in truncation from an open state or an escape
    a_r7_trunc_needs_last: assert property (@(posedge clk) disable iff (rst)
        trunc |-> (take && byte_last));

    // R2: after a value byte the parser is waiting for a count
    a_r2_count_follows_value: assert property (@(posedge clk) disable iff (rst)
        (ps_q.st == PS_VAL && !take) |=> (ps_q.st == PS_VAL));

endmodule

// File: rtl/rle_run_emitter.sv
module rle_run_emitter #(
    parameter int  DATA_W = 8,
    localparam int CNT_W  = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              slot_free
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
        logic [CNT_W-1:0]  rem;   // copies left, including the one shown
    } estate_t;

    estate_t em_d, em_q;

    always_comb begin
        em_d = em_q;
        // counter moves only on an output handshake
        if (em_q.vld && out_ready) begin
            if (em_q.rem == CNT_W'(1)) em_d.vld = 1'b0;
            else                       em_d.rem = em_q.rem - CNT_W'(1);
        end
        if (load) begin
            em_d.vld = 1'b1;
            em_d.dat = load_data;
            em_d.rem = load_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            em_q.vld <= 1'b0;
            em_q.dat <= '0;
            em_q.rem <= '0;
        end else begin
            em_q <= em_d;
        end
    end

    assign out_valid = em_q.vld;
    assign out_data  = em_q.dat;
    assign slot_free = !em_q.vld || (out_ready && em_q.rem == CNT_W'(1));

    // R5: a stalled byte is held unchanged
    a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (em_q.vld && !out_ready) |=> (em_q.vld && $stable(em_q.dat)));

    // R6: the parser only loads into a free slot
    a_r6_load_into_free_slot: assert property (@(posedge clk) disable iff (rst)
        load |-> slot_free);

    // R2: a shown byte always has at least one copy left
    a_r2_rem_nonzero: assert property (@(posedge clk) disable iff (rst)
        em_q.vld |-> (em_q.rem != '0));

endmodule

// File: rtl/rle_escape_expander.sv
module rle_escape_expander #(
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] ESC_CODE = 8'h81
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic              err_trunc
);

    localparam int CNT_W = DATA_W + 1;

    logic              take;
    logic              load;
    logic [DATA_W-1:0] load_data;
    logic [CNT_W-1:0]  load_cnt;
    logic              trunc;
    logic              slot_free;
    logic              err_d, err_q;

    assign in_ready = slot_free;
    assign take     = in_valid && in_ready;

    rle_group_parser #(
        .DATA_W   (DATA_W),
        .ESC_CODE (ESC_CODE)
    ) u_parser (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .byte_in   (in_data),
        .byte_last (in_last),
        .load      (load),
        .load_data (load_data),
        .load_cnt  (load_cnt),
        .trunc     (trunc)
    );

    rle_run_emitter #(
        .DATA_W (DATA_W)
    ) u_emitter (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (load_data),
        .load_cnt  (load_cnt),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .slot_free (slot_free)
    );

    always_comb err_d = err_q | trunc;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_d;
    end

    assign err_trunc = err_q;

    // R8: the error flag never clears without reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R7: the flag rises only after an accepted byte with the end marker
    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(in_valid && in_ready && in_last));

    // R9: while the output is idle, input is always accepted
    a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

endmodule

// File: tb/rle_escape_expander_bench.sv
module rle_escape_expander_bench;

    localparam logic [7:0] ESC = 8'h81;
    localparam int N_STIM = 22;

    // {in_last, byte}
    localparam logic [8:0] STIM [0:N_STIM-1] = '{
        9'h012, 9'h034,                  // literals
        9'h081, 9'h055, 9'h003,          // run of 3
        9'h081, 9'h081, 9'h001,          // literal escape
        9'h081, 9'h0AA, 9'h000,          // run of 256
        9'h081, 9'h07E, 9'h1FF,          // run of 255, end marker on count
        9'h156,                          // literal with end marker
        9'h080, 9'h082,                  // neighbours of the escape
        9'h081, 9'h000, 9'h002,          // value zero, run of 2
        9'h081, 9'h0C3                   // escape opens, value C3 ...
    };
    // last entry completed by an extra count byte sent after the loop

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready;
    logic       err_trunc;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] got [$];
    logic [7:0] exp_q [$];
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;

    always #5 clk = ~clk;

    rle_escape_expander u_rle_escape_expander (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .err_trunc (err_trunc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // consumer: drives out_ready, records bytes, checks stall stability (R5)
    initial begin
        out_ready = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = lfsr[0] | lfsr[3];
                default: out_ready = 1'b0;
            endcase
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            if (rst) begin
                prev_stall = 1'b0;
            end else begin
                if (prev_stall) begin
                    check(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
                    check(out_data == prev_data, "R5 data held", int'(out_data), int'(prev_data));
                end
                if (out_valid && out_ready) got.push_back(out_data);
                prev_stall = out_valid && !out_ready;
                prev_data  = out_data;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic lst);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = lst;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic drain_compare(input string tag);
        int guard = 0;
        while (got.size() < exp_q.size() && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        repeat (4) @(posedge clk);
        #1;
        check(got.size() == exp_q.size(), {tag, " byte count"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            check(got[i] == exp_q[i], tag, int'(got[i]), int'(exp_q[i]));
        got.delete();
        exp_q.delete();
    endtask

    // reference expansion of the stimulus table from the requirements
    task automatic build_expected(output bit model_err);
        int st = 0;
        logic [7:0] v = 8'h00;
        model_err = 1'b0;
        for (int i = 0; i < N_STIM; i++) begin
            logic [7:0] b = STIM[i][7:0];
            logic       l = STIM[i][8];
            case (st)
                0: if (b == ESC) begin
                       if (l) model_err = 1'b1; else st = 1;
                   end else exp_q.push_back(b);
                1: begin v = b; if (l) begin model_err = 1'b1; st = 0; end else st = 2; end
                default: begin
                    int n = (b == 8'h00) ? 256 : int'(b);
                    for (int k = 0; k < n; k++) exp_q.push_back(v);
                    st = 0;
                end
            endcase
        end
        // closing count byte 8'h04 for the final open group
        for (int k = 0; k < 4; k++) exp_q.push_back(v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit merr;
        do_reset();
        @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R9 in_ready after reset", int'(in_ready), 1);
        check(err_trunc == 1'b0, "R9 err after reset", int'(err_trunc), 0);
        @(posedge clk);
        #1;

        // table walk: R1 R2 R3 R4 R10, free flow then random stalls (R5)
        for (int pass = 0; pass < 2; pass++) begin
            rdy_mode = pass;
            build_expected(merr);
            foreach (STIM[i]) send_byte(STIM[i][7:0], STIM[i][8]);
            send_byte(8'h04, 1'b0);
            drain_compare(pass == 0 ? "R1_R2_R3_R4_R10 free" : "R1_R2_R3_R4_R5 stalled");
            // R8: end marker on a literal or count byte leaves the flag clear
            check(err_trunc == merr, "R8 no error on complete groups", int'(err_trunc), int'(merr));
        end

        // R6: input blocked while a run is held, order kept after release
        rdy_mode = 2;
        repeat (2) @(posedge clk);
        #1;
        send_byte(ESC, 1'b0);
        send_byte(8'h33, 1'b0);
        send_byte(8'h03, 1'b0);
        fork
            send_byte(8'h44, 1'b0);
            begin
                repeat (4) @(negedge clk);
                check(in_ready == 1'b0, "R6 in_ready low during run", int'(in_ready), 0);
                check(out_data == 8'h33, "R6 held run byte", int'(out_data), 8'h33);
                rdy_mode = 0;
            end
        join
        exp_q = '{8'h33, 8'h33, 8'h33, 8'h44};
        drain_compare("R6 order after stall");

        // R7: end marker on the opening escape
        send_byte(ESC, 1'b1);
        check(err_trunc == 1'b1, "R7 err after escape+last", int'(err_trunc), 1);
        send_byte(8'h41, 1'b0);
        exp_q = '{8'h41};
        drain_compare("R7 partial dropped, next is literal");
        // R8: still set
        check(err_trunc == 1'b1, "R8 err sticky", int'(err_trunc), 1);

        // R9: reset clears the flag
        do_reset();
        @(negedge clk);
        check(err_trunc == 1'b0, "R9 err cleared by reset", int'(err_trunc), 0);
        @(posedge clk);
        #1;

        // R7: end marker on the value byte
        send_byte(ESC, 1'b0);
        send_byte(8'h22, 1'b1);
        check(err_trunc == 1'b1, "R7 err after value+last", int'(err_trunc), 1);
        send_byte(8'h02, 1'b0);
        exp_q = '{8'h02};
        drain_compare("R7 count byte decoded as literal");

        // R8: end marker on the count byte does not set the flag
        do_reset();
        send_byte(ESC, 1'b0);
        send_byte(8'h22, 1'b0);
        send_byte(8'h02, 1'b1);
        exp_q = '{8'h22, 8'h22};
        drain_compare("R8 complete group with end marker");
        check(err_trunc == 1'b0, "R8 no error on count+last", int'(err_trunc), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule